// File: doc/BRIEF.md
# Scanline Detection IRQ Unit

This block tells a CPU which scanline the picture processor is drawing, using nothing but the addresses on the picture processor's memory bus. It has no connection to the video timing. At the end of every rendered line the picture processor reads the same nametable byte several times in a row. The block looks for three identical reads in the nametable window and treats each such run as a line boundary. The first boundary of a frame marks the start of the frame. Each later boundary advances an 8-bit line counter.

When the advanced counter equals a programmed target line, an internal pending flag latches. If the enable bit is set, that flag also drives an active-high interrupt towards the CPU. Several events make the block forget the frame:
- the CPU fetching the non-maskable interrupt vector;
- the picture-processor bus going quiet for a few CPU clocks;
- software turning rendering off.

The block gets one clock per CPU cycle. On each cycle it may see one picture-processor read and one CPU bus access.

Top module: `irq_scanline_unit`

## Requirements
- R1: After reset, `irq_out` is low and `status_byte` is 0x00. The in-frame flag, both pending flags, the enable bit, the target and the line counter all start at zero.
- R2: Only picture-processor reads whose address bits 13:12 equal 2'b10 (0x2000-0x2FFF) are compared with the previously remembered address. Reads outside that window change neither the remembered address nor the run count. The third identical read in a row is a line boundary. A boundary seen while out of frame sets the in-frame flag (`status_byte` bit 6) and zeroes the line counter.
- R3: A boundary seen while in frame advances the line counter. When the new value equals the target register (CPU write to 0x5203), the internal pending flag sets. The visible pending flag (`status_byte` bit 7) also sets if the enable bit (bit 7 of the last CPU write to 0x5204) is 1.
- R4: A CPU write to 0x5204 with bit 7 = 0 clears the visible pending flag. A write with bit 7 = 1 while the internal flag is latched sets it, so `irq_out` is high from the next cycle.
- R5: `status_byte` presents the visible pending flag in bit 7, the in-frame flag in bit 6, and zeros elsewhere. A CPU read of 0x5204 clears both pending flags. A target hit in the same cycle as that read still leaves both flags set.
- R6: A CPU read of 0xFFFA or 0xFFFB clears the in-frame flag, the remembered address and both pending flags. This takes priority over a boundary or hit in the same cycle.
- R7: After three consecutive cycles with no picture-processor read, the in-frame flag clears and the remembered address is forgotten.
- R8: A CPU write to 0x2001 with data bits 4:3 both 0 clears the in-frame flag and the remembered address. A write to 0x2001 with either bit set has no effect.
- R9: The line counter saturates at 255 and does not wrap, so a target of 0 never produces a hit.
- R10: `irq_out` is the OR of the visible pending flag and the `ext_irq` input.
- R11: A differing nametable address restarts the run. A fourth or later identical read after a boundary produces no further boundary.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | CPU-rate clock |
| rst | input | 1 | Synchronous active-high reset |
| ppu_rd | input | 1 | Picture-processor read strobe for this cycle |
| ppu_addr | input | 14 | Picture-processor read address |
| cpu_rd | input | 1 | CPU read strobe |
| cpu_wr | input | 1 | CPU write strobe |
| cpu_addr | input | 16 | CPU bus address |
| cpu_wdata | input | 8 | CPU write data |
| ext_irq | input | 1 | Other interrupt sources to merge |
| irq_out | output | 1 | Active-high interrupt request |
| status_byte | output | 8 | {visible pending, in-frame, 6'b0} |

## Verification
Two functions can fall in the same cycle:
- a CPU acknowledge read of 0x5204 and the third identical nametable read that reaches the target line;
- a vector fetch and a target hit.

The bench places the CPU read in exactly the cycle of the third identical read. The reference model applies the documented priority: a new hit survives the acknowledge, and the vector fetch wins over a hit. The model then compares `irq_out` and `status_byte` on the following cycles.

// File: rtl/scanirq_pkg.sv
package scanirq_pkg;

    localparam int PPU_AW = 14;
    localparam int CPU_AW = 16;
    localparam int DW     = 8;

    localparam logic [CPU_AW-1:0] VEC_LO_ADDR = 16'hFFFA;
    localparam logic [CPU_AW-1:0] VEC_HI_ADDR = 16'hFFFB;
    localparam logic [CPU_AW-1:0] RENDER_ADDR = 16'h2001;
    localparam logic [CPU_AW-1:0] TARGET_ADDR = 16'h5203;
    localparam logic [CPU_AW-1:0] CTRL_ADDR   = 16'h5204;

    // One cycle's worth of decoded CPU bus events
    typedef struct packed {
        logic vec_fetch;
        logic render_off;
        logic ack;
        logic ctrl_wr;
        logic ctrl_en;
        logic tgt_wr;
    } cpu_evt_t;

    function automatic logic in_nt_window(input logic [PPU_AW-1:0] a);
        return a[PPU_AW-1 -: 2] == 2'b10;
    endfunction

endpackage

// File: rtl/sirq_cpu_decode.sv
module sirq_cpu_decode
    import scanirq_pkg::*;
(
    input  logic              cpu_rd,
    input  logic              cpu_wr,
    input  logic [CPU_AW-1:0] cpu_addr,
    input  logic [DW-1:0]     cpu_wdata,
    output cpu_evt_t          evt
);
    always_comb begin
        evt            = '0;
        evt.vec_fetch  = cpu_rd && (cpu_addr == VEC_LO_ADDR || cpu_addr == VEC_HI_ADDR);
        evt.render_off = cpu_wr && (cpu_addr == RENDER_ADDR) && (cpu_wdata[4:3] == 2'b00);
        evt.ack        = cpu_rd && (cpu_addr == CTRL_ADDR);
        evt.ctrl_wr    = cpu_wr && (cpu_addr == CTRL_ADDR);
        evt.ctrl_en    = cpu_wdata[DW-1];
        evt.tgt_wr     = cpu_wr && (cpu_addr == TARGET_ADDR);
    end
endmodule

// File: rtl/sirq_run_detect.sv
module sirq_run_detect
    import scanirq_pkg::*;
#(
    parameter int RUN_LEN    = 2,
    parameter int IDLE_LIMIT = 3
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              ppu_rd,
    input  logic [PPU_AW-1:0] ppu_addr,
    input  logic              forget,
    output logic              boundary,
    output logic              timeout
);
    localparam int MW = $clog2(RUN_LEN + 2);
    localparam int IW = $clog2(IDLE_LIMIT + 1);
    localparam logic [MW-1:0] M_SAT  = MW'(RUN_LEN + 1);
    localparam logic [MW-1:0] M_LAST = MW'(RUN_LEN - 1);
    localparam logic [IW-1:0] I_LAST = IW'(IDLE_LIMIT - 1);

    logic [PPU_AW-1:0] prev_q, prev_d;
    logic              valid_q, valid_d;
    logic [MW-1:0]     match_q, match_d;
    logic [IW-1:0]     idle_q, idle_d;
    logic              nt, same;

    always_comb begin
        nt       = ppu_rd && in_nt_window(ppu_addr);
        same     = valid_q && (ppu_addr == prev_q);
        match_d  = match_q;
        prev_d   = prev_q;
        boundary = 1'b0;
        timeout  = 1'b0;
        idle_d   = idle_q;
        if (nt) begin
            prev_d = ppu_addr;
            if (same) begin
                match_d  = (match_q == M_SAT) ? match_q : match_q + 1'b1;
                boundary = (match_q == M_LAST);
            end else begin
                match_d = '0;
            end
        end
        if (ppu_rd) begin
            idle_d = '0;
        end else if (idle_q == I_LAST) begin
            idle_d  = '0;
            timeout = 1'b1;
        end else begin
            idle_d = idle_q + 1'b1;
        end
        if (forget || timeout) valid_d = 1'b0;
        else if (nt)           valid_d = 1'b1;
        else                   valid_d = valid_q;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            prev_q  <= '0;
            valid_q <= 1'b0;
            match_q <= '0;
            idle_q  <= '0;
        end else begin
            prev_q  <= prev_d;
            valid_q <= valid_d;
            match_q <= match_d;
            idle_q  <= idle_d;
        end
    end
endmodule

// File: rtl/sirq_line_track.sv
module sirq_line_track
    import scanirq_pkg::*;
#(
    parameter int LW = 8
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          boundary,
    input  logic          clr_frame,
    input  cpu_evt_t      evt,
    input  logic [LW-1:0] tgt_val,
    output logic          in_frame,
    output logic          pend_vis
);
    localparam logic [LW-1:0] L_MAX = '1;

    logic [LW-1:0] line_q, line_d, tgt_q;
    logic          frame_d, en_q, en_d, pi_q, pi_d, pv_d;

    always_comb begin
        line_d  = line_q;
        frame_d = in_frame;
        en_d    = en_q;
        pi_d    = pi_q;
        pv_d    = pend_vis;
        if (evt.ctrl_wr) begin
            en_d = evt.ctrl_en;
            if (!evt.ctrl_en) pv_d = 1'b0;
            else if (pi_q)    pv_d = 1'b1;
        end
        if (evt.ack) begin
            pi_d = 1'b0;
            pv_d = 1'b0;
        end
        if (boundary) begin
            if (in_frame) begin
                line_d = (line_q == L_MAX) ? line_q : line_q + 1'b1;
                if (line_d == tgt_q) begin
                    pi_d = 1'b1;
                    if (en_d) pv_d = 1'b1;
                end
            end else begin
                frame_d = 1'b1;
                line_d  = '0;
            end
        end
        if (clr_frame) frame_d = 1'b0;
        if (evt.vec_fetch) begin
            pi_d = 1'b0;
            pv_d = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            line_q   <= '0;
            tgt_q    <= '0;
            in_frame <= 1'b0;
            en_q     <= 1'b0;
            pi_q     <= 1'b0;
            pend_vis <= 1'b0;
        end else begin
            line_q   <= line_d;
            in_frame <= frame_d;
            en_q     <= en_d;
            pi_q     <= pi_d;
            pend_vis <= pv_d;
            if (evt.tgt_wr) tgt_q <= tgt_val;
        end
    end
endmodule

// File: rtl/irq_scanline_unit.sv
module irq_scanline_unit
    import scanirq_pkg::*;
#(
    parameter int LINE_W     = 8,
    parameter int RUN_LEN    = 2,
    parameter int IDLE_LIMIT = 3
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              ppu_rd,
    input  logic [PPU_AW-1:0] ppu_addr,
    input  logic              cpu_rd,
    input  logic              cpu_wr,
    input  logic [CPU_AW-1:0] cpu_addr,
    input  logic [DW-1:0]     cpu_wdata,
    input  logic              ext_irq,
    output logic              irq_out,
    output logic [DW-1:0]     status_byte
);
    cpu_evt_t evt;
    logic     boundary, timeout, in_frame, pend_vis;

    sirq_cpu_decode u_dec (
        .cpu_rd   (cpu_rd),
        .cpu_wr   (cpu_wr),
        .cpu_addr (cpu_addr),
        .cpu_wdata(cpu_wdata),
        .evt      (evt)
    );

    sirq_run_detect #(.RUN_LEN(RUN_LEN), .IDLE_LIMIT(IDLE_LIMIT)) u_det (
        .clk     (clk),
        .rst     (rst),
        .ppu_rd  (ppu_rd),
        .ppu_addr(ppu_addr),
        .forget  (evt.render_off | evt.vec_fetch),
        .boundary(boundary),
        .timeout (timeout)
    );

    sirq_line_track #(.LW(LINE_W)) u_trk (
        .clk      (clk),
        .rst      (rst),
        .boundary (boundary),
        .clr_frame(timeout | evt.render_off | evt.vec_fetch),
        .evt      (evt),
        .tgt_val  (cpu_wdata[LINE_W-1:0]),
        .in_frame (in_frame),
        .pend_vis (pend_vis)
    );

    assign irq_out     = pend_vis | ext_irq;
    assign status_byte = {pend_vis, in_frame, {(DW-2){1'b0}}};
endmodule

// File: rtl/sirq_checker.sv
module sirq_checker (
    input logic        clk,
    input logic        rst,
    input logic        ppu_rd,
    input logic        cpu_rd,
    input logic        cpu_wr,
    input logic [15:0] cpu_addr,
    input logic [7:0]  cpu_wdata,
    input logic        ext_irq,
    input logic        irq_out,
    input logic [7:0]  status_byte
);
    logic [1:0] quiet;
    always_ff @(posedge clk) begin
        if (rst || ppu_rd) quiet <= 2'd0;
        else if (quiet != 2'd3) quiet <= quiet + 2'd1;
    end

    assert_irq_merge_R10: assert property (@(posedge clk) disable iff (rst)
        irq_out == (status_byte[7] | ext_irq));

    assert_vector_clear_R6: assert property (@(posedge clk) disable iff (rst)
        (cpu_rd && (cpu_addr == 16'hFFFA || cpu_addr == 16'hFFFB)) |=> (status_byte[7:6] == 2'b00));

    assert_render_off_R8: assert property (@(posedge clk) disable iff (rst)
        (cpu_wr && cpu_addr == 16'h2001 && cpu_wdata[4:3] == 2'b00) |=> !status_byte[6]);

    assert_disable_drop_R4: assert property (@(posedge clk) disable iff (rst)
        (cpu_wr && cpu_addr == 16'h5204 && !cpu_wdata[7]) |=> !status_byte[7]);

    assert_ack_clear_R5: assert property (@(posedge clk) disable iff (rst)
        (cpu_rd && cpu_addr == 16'h5204 && !ppu_rd) |=> !status_byte[7]);

    assert_idle_exit_R7: assert property (@(posedge clk) disable iff (rst)
        (quiet == 2'd3) |-> !status_byte[6]);
endmodule

bind irq_scanline_unit sirq_checker u_chk (
    .clk        (clk),
    .rst        (rst),
    .ppu_rd     (ppu_rd),
    .cpu_rd     (cpu_rd),
    .cpu_wr     (cpu_wr),
    .cpu_addr   (cpu_addr),
    .cpu_wdata  (cpu_wdata),
    .ext_irq    (ext_irq),
    .irq_out    (irq_out),
    .status_byte(status_byte)
);

// File: tb/tb_irq_scanline_unit.sv
module tb_irq_scanline_unit;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        ppu_rd = 1'b0;
    logic [13:0] ppu_addr = '0;
    logic        cpu_rd = 1'b0, cpu_wr = 1'b0;
    logic [15:0] cpu_addr = '0;
    logic [7:0]  cpu_wdata = '0;
    logic        ext_irq = 1'b0;
    logic        irq_out;
    logic [7:0]  status_byte;

    always #2 clk = ~clk;

    irq_scanline_unit dut (
        .clk(clk), .rst(rst), .ppu_rd(ppu_rd), .ppu_addr(ppu_addr),
        .cpu_rd(cpu_rd), .cpu_wr(cpu_wr), .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata),
        .ext_irq(ext_irq), .irq_out(irq_out), .status_byte(status_byte)
    );

    int checks = 0, fails = 0;
    bit done = 0;

    // behavioural reference state
    int m_prev, m_match, m_idle, m_line, m_tgt;
    bit m_frame, m_en, m_pi, m_pv;

    task automatic model_reset();
        m_prev = -1; m_match = 0; m_idle = 0; m_line = 0; m_tgt = 0;
        m_frame = 0; m_en = 0; m_pi = 0; m_pv = 0;
    endtask

    task automatic model_step();
        bit nt, bnd, tmo, roff, vec;
        nt = ppu_rd && ppu_addr[13:12] == 2'b10;
        bnd = 0; tmo = 0;
        if (nt) begin
            if (m_prev == int'(ppu_addr)) begin
                m_match = (m_match + 1 > 3) ? 3 : m_match + 1;
                bnd = (m_match == 2);
            end else m_match = 0;
            m_prev = int'(ppu_addr);
        end
        if (ppu_rd) m_idle = 0;
        else begin
            m_idle++;
            if (m_idle == 3) begin m_idle = 0; tmo = 1; end
        end
        roff = cpu_wr && cpu_addr == 16'h2001 && cpu_wdata[4:3] == 0;
        vec  = cpu_rd && (cpu_addr == 16'hFFFA || cpu_addr == 16'hFFFB);
        if (cpu_wr && cpu_addr == 16'h5204) begin
            m_en = cpu_wdata[7];
            if (!m_en) m_pv = 0; else if (m_pi) m_pv = 1;
        end
        if (cpu_rd && cpu_addr == 16'h5204) begin m_pi = 0; m_pv = 0; end
        if (bnd) begin
            if (m_frame) begin
                if (m_line < 255) m_line++;
                if (m_line == m_tgt) begin m_pi = 1; if (m_en) m_pv = 1; end
            end else begin m_frame = 1; m_line = 0; end
        end
        if (cpu_wr && cpu_addr == 16'h5203) m_tgt = cpu_wdata;
        if (tmo || roff || vec) begin m_frame = 0; m_prev = -1; end
        if (vec) begin m_pi = 0; m_pv = 0; end
    endtask

    task automatic compare(string tag);
        logic [7:0] exp_s;
        logic       exp_i;
        exp_s = {m_pv, m_frame, 6'b0};
        exp_i = m_pv | ext_irq;
        checks++;
        if (status_byte !== exp_s || irq_out !== exp_i) begin
            fails++;
            $display("FAIL %s: status=%02h irq=%b expected status=%02h irq=%b",
                     tag, status_byte, irq_out, exp_s, exp_i);
        end
    endtask

    // one cycle: inputs already driven after a falling edge
    task automatic cyc(string tag, bit prd, logic [13:0] pa,
                       bit cr, bit cw, logic [15:0] ca, logic [7:0] cd);
        ppu_rd = prd; ppu_addr = pa; cpu_rd = cr; cpu_wr = cw;
        cpu_addr = ca; cpu_wdata = cd;
        #1;
        compare(tag);
        model_step();
        @(negedge clk);
    endtask

    task automatic nt(string tag, logic [13:0] a);
        cyc(tag, 1, a, 0, 0, 16'h0, 8'h0);
    endtask
    task automatic pat(string tag);
        cyc(tag, 1, 14'h0100, 0, 0, 16'h0, 8'h0);
    endtask
    task automatic quiet(string tag);
        cyc(tag, 0, 14'h0, 0, 0, 16'h0, 8'h0);
    endtask
    task automatic cpuw(string tag, logic [15:0] a, logic [7:0] d);
        cyc(tag, 1, 14'h0100, 0, 1, a, d);
    endtask
    task automatic cpur(string tag, logic [15:0] a);
        cyc(tag, 1, 14'h0100, 1, 0, a, 8'h0);
    endtask
    task automatic line(string tag, int k);
        logic [13:0] a;
        a = 14'h2000 + 14'(k % 960);
        nt(tag, a); nt(tag, a); nt(tag, a); pat(tag);
    endtask
    task automatic restart(string tag);
        cpur(tag, 16'hFFFA);
        quiet(tag); quiet(tag); quiet(tag);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            fails++; checks++;
            $display("FAIL watchdog: run did not complete, expected completion");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        model_reset();
        repeat (3) @(negedge clk);
        rst = 1'b0;
        // R1 reset state
        quiet("R1"); quiet("R1");
        // R2 window and first boundary; 0x3000 reads are not compared
        nt("R2", 14'h3000); nt("R2", 14'h3000); nt("R2", 14'h3000); pat("R2");
        line("R2", 0); pat("R2");
        // R3 target 3 with enable
        cpuw("R3", 16'h5203, 8'd3); cpuw("R3", 16'h5204, 8'h80);
        for (int k = 1; k <= 3; k++) line("R3", k);
        pat("R3"); pat("R3");
        // R5 acknowledge
        cpur("R5", 16'h5204); pat("R5"); pat("R5");
        // R4 disabled hit then late enable and disable
        restart("R4");
        cpuw("R4", 16'h5204, 8'h00); cpuw("R4", 16'h5203, 8'd2);
        for (int k = 0; k <= 2; k++) line("R4", k);
        pat("R4");
        cpuw("R4", 16'h5204, 8'h80); pat("R4");
        cpuw("R4", 16'h5204, 8'h00); pat("R4");
        cpuw("R4", 16'h5204, 8'h80); pat("R4");
        // R6 vector fetch clears pending and frame
        cpur("R6", 16'hFFFB); pat("R6");
        // R5 acknowledge in the same cycle as a hit
        restart("R5");
        cpuw("R5", 16'h5203, 8'd1);
        line("R5", 0);
        nt("R5", 14'h2040); nt("R5", 14'h2040);
        cyc("R5", 1, 14'h2040, 1, 0, 16'h5204, 8'h0);
        pat("R5"); cpur("R5", 16'h5204); pat("R5");
        // R6 vector fetch in the same cycle as a hit
        restart("R6");
        line("R6", 0);
        nt("R6", 14'h2041); nt("R6", 14'h2041);
        cyc("R6", 1, 14'h2041, 1, 0, 16'hFFFA, 8'h0);
        pat("R6"); pat("R6");
        // R7 two quiet cycles keep frame, three drop it
        line("R7", 0);
        quiet("R7"); quiet("R7"); pat("R7"); pat("R7");
        quiet("R7"); quiet("R7"); quiet("R7"); pat("R7");
        // R8 rendering on keeps frame, off clears it
        line("R8", 0);
        cpuw("R8", 16'h2001, 8'h18); pat("R8");
        cpuw("R8", 16'h2001, 8'h08); pat("R8");
        cpuw("R8", 16'h2001, 8'h00); pat("R8");
        // R11 broken runs and over-long runs
        nt("R11", 14'h2100); nt("R11", 14'h2100); nt("R11", 14'h2101);
        nt("R11", 14'h2100); nt("R11", 14'h2100); pat("R11");
        nt("R11", 14'h2100); nt("R11", 14'h2100); pat("R11");
        cpuw("R11", 16'h5203, 8'd1);
        nt("R11", 14'h2100); nt("R11", 14'h2100); nt("R11", 14'h2100); pat("R11");
        nt("R11", 14'h2200); nt("R11", 14'h2200); nt("R11", 14'h2200); pat("R11");
        cpur("R11", 16'h5204);
        // R9 target zero over more than 256 lines
        restart("R9");
        cpuw("R9", 16'h5203, 8'd0);
        for (int k = 0; k < 300; k++) line("R9", k);
        // R10 external source merged
        ext_irq = 1'b1; pat("R10"); pat("R10");
        ext_irq = 1'b0; pat("R10");
        done = 1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule